// File: doc/BRIEF.md
# Masked Interrupt and DMA Request Router

This block gathers thirteen event sources into one sticky request vector. A mask register then folds that vector into a single active-high CPU interrupt line. Event pulses from the data path and the command sequencer set request bits. Software removes them with per-bit clear strobes. The two FIFO-service bits are also removed as a side effect of the FIFO being popped (receive) or pushed (transmit). The mask is loaded from a plain register-bus write strobe with a full-width data word.

A DMA-mode input comes from the command/data control word. While it is high, the receive and transmit FIFO-service bits no longer reach the CPU interrupt, whatever the mask register holds. Instead, each one drives its own DMA request line. While DMA mode is low, both DMA request lines stay low. All outputs are combinational functions of the registered request and mask state and the DMA-mode input.

Top module: `irq_dma_router`

## Requirements
- R1: After a synchronous reset, every request bit and every mask bit is 0, and all three request outputs are low.
- R2: A pulse on event input bit k sets request bit k on the next clock edge. The bit stays set on later cycles until it is cleared.
- R3: A pulse on clear strobe bit k clears request bit k on the next clock edge.
- R4: When a set event and any clear source hit the same bit in the same cycle, that bit ends up set.
- R5: The receive-pop side effect clears request bit 5 (receive FIFO service). The transmit-push side effect clears request bit 6 (transmit FIFO service). No other bit is touched by these side effects.
- R6: A mask write keeps only bits 12..0 of the 32-bit write data. The upper data bits have no effect on the stored mask.
- R7: The interrupt is high exactly when some request bit is set and its effective mask bit is 0. A mask write changes the interrupt from the cycle after the write edge.
- R8: While DMA mode is high, request bits 5 and 6 never raise the interrupt, even when their mask bits are 0.
- R9: While DMA mode is high, the receive DMA request equals request bit 5 and the transmit DMA request equals request bit 6, regardless of the mask.
- R10: While DMA mode is low, both DMA request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set_i | input | 13 | Per-bit event pulses that set request bits |
| clr_strobe_i | input | 13 | Per-bit software clear strobes |
| rx_pop_i | input | 1 | Receive FIFO read side effect; clears bit 5 |
| tx_push_i | input | 1 | Transmit FIFO write side effect; clears bit 6 |
| mask_wr_en_i | input | 1 | Mask register write strobe |
| mask_wr_data_i | input | 32 | Mask write data; bits 12..0 are kept |
| dma_mode_i | input | 1 | DMA enable from the command/data control word |
| irq_o | output | 1 | CPU interrupt, active high |
| dma_rx_req_o | output | 1 | Receive DMA request |
| dma_tx_req_o | output | 1 | Transmit DMA request |
| req_bits_o | output | 13 | Current request vector |
| mask_bits_o | output | 13 | Current mask register |

## Verification
Two functions can fall in the same cycle on one request bit: the event that sets it, and a clear from either a software strobe or a FIFO side effect. The bench provokes this by driving an event together with a strobe on bit 9. It then drives a transmit-service event together with a transmit push on bit 6. In both cases the bit must read back set, and the interrupt or DMA line it feeds must follow. The bench also flips DMA mode while both FIFO-service bits are pending, so that the same request state is judged under both steering rules.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int SRC_N = 13;
    localparam int BUS_W = 32;

    typedef enum int unsigned {
        SRC_XFER_DONE = 0,
        SRC_PROG_DONE = 1,
        SRC_CMD_END   = 2,
        SRC_STOP_CMD  = 3,
        SRC_CLK_OFF   = 4,
        SRC_RX_SVC    = 5,
        SRC_TX_SVC    = 6,
        SRC_XFER_TMR  = 7,
        SRC_DATA_ERR  = 8,
        SRC_RESP_ERR  = 9,
        SRC_RD_STALL  = 10,
        SRC_CARD_INT  = 11,
        SRC_SUSP_ACK  = 12
    } src_idx_e;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef struct packed {
        logic irq;
        logic dma_rx;
        logic dma_tx;
    } route_out_t;

    function automatic src_vec_t one_hot(input int unsigned idx);
        src_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic src_vec_t fifo_svc_bits();
        return one_hot(int'(SRC_RX_SVC)) | one_hot(int'(SRC_TX_SVC));
    endfunction

endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int N = irq_route_pkg::SRC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] req_q
);
    // One sticky flop per source; a set beats a clear in the same cycle.
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (set_vec[g]) begin
                bit_q <= 1'b1;
            end else if (clr_vec[g]) begin
                bit_q <= 1'b0;
            end
        end
        assign req_q[g] = bit_q;
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int N = irq_route_pkg::SRC_N,
    parameter int W = irq_route_pkg::BUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [N-1:0] mask_q
);
    localparam int KEEP = (N < W) ? N : W;

    logic [N-1:0] next_mask;

    always_comb begin
        next_mask = '0;
        next_mask[KEEP-1:0] = wr_data[KEEP-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= next_mask;
        end
    end
endmodule

// File: rtl/irq_route_logic.sv
module irq_route_logic
    import irq_route_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] mask,
    input  logic         dma_mode,
    output route_out_t   route
);
    localparam int RX_POS = int'(SRC_RX_SVC);
    localparam int TX_POS = int'(SRC_TX_SVC);

    logic [N-1:0] dma_steal;
    logic [N-1:0] eff_mask;
    logic [N-1:0] pending;

    // In DMA mode the FIFO-service bits are stolen from the CPU path.
    for (genvar g = 0; g < N; g++) begin : g_src
        if (g == RX_POS || g == TX_POS) begin : g_svc
            assign dma_steal[g] = dma_mode;
        end else begin : g_plain
            assign dma_steal[g] = 1'b0;
        end
        assign eff_mask[g] = mask[g] | dma_steal[g];
        assign pending[g]  = req[g] & ~eff_mask[g];
    end

    always_comb begin
        route.irq    = |pending;
        route.dma_rx = dma_mode & req[RX_POS];
        route.dma_tx = dma_mode & req[TX_POS];
    end
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
    import irq_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SRC_N-1:0]    evt_set_i,
    input  logic [SRC_N-1:0]    clr_strobe_i,
    input  logic                rx_pop_i,
    input  logic                tx_push_i,
    input  logic                mask_wr_en_i,
    input  logic [BUS_W-1:0]    mask_wr_data_i,
    input  logic                dma_mode_i,
    output logic                irq_o,
    output logic                dma_rx_req_o,
    output logic                dma_tx_req_o,
    output logic [SRC_N-1:0]    req_bits_o,
    output logic [SRC_N-1:0]    mask_bits_o
);
    src_vec_t   req_q;
    src_vec_t   mask_q;
    src_vec_t   clr_all;
    route_out_t route;

    // Software strobes merged with the FIFO access side effects.
    always_comb begin
        clr_all = clr_strobe_i;
        if (rx_pop_i)  clr_all = clr_all | one_hot(int'(SRC_RX_SVC));
        if (tx_push_i) clr_all = clr_all | one_hot(int'(SRC_TX_SVC));
    end

    irq_req_bank #(.N(SRC_N)) u_req (
        .clk     (clk),
        .rst     (rst),
        .set_vec (evt_set_i),
        .clr_vec (clr_all),
        .req_q   (req_q)
    );

    irq_mask_reg #(.N(SRC_N), .W(BUS_W)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mask_wr_en_i),
        .wr_data (mask_wr_data_i),
        .mask_q  (mask_q)
    );

    irq_route_logic #(.N(SRC_N)) u_route (
        .req      (req_q),
        .mask     (mask_q),
        .dma_mode (dma_mode_i),
        .route    (route)
    );

    assign irq_o        = route.irq;
    assign dma_rx_req_o = route.dma_rx;
    assign dma_tx_req_o = route.dma_tx;
    assign req_bits_o   = req_q;
    assign mask_bits_o  = mask_q;
endmodule

// File: rtl/irq_dma_router_chk.sv
module irq_dma_router_chk
    import irq_route_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [SRC_N-1:0] evt_set,
    input logic [SRC_N-1:0] clr_all,
    input logic             mask_wr_en,
    input logic [BUS_W-1:0] mask_wr_data,
    input logic             dma_mode,
    input logic [SRC_N-1:0] req_q,
    input logic [SRC_N-1:0] mask_q,
    input logic             irq_o,
    input logic             dma_rx_req_o,
    input logic             dma_tx_req_o
);
    logic run_q;
    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= 1'b1;
    end

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (req_q == '0 && mask_q == '0));

    // R2
    a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
        (|evt_set) |=> ((req_q & $past(evt_set)) == $past(evt_set)));

    // R2
    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        run_q |=> (((req_q ^ $past(req_q)) & ~$past(evt_set | clr_all)) == '0));

    // R3, R5
    a_r3_clear_lands: assert property (@(posedge clk) disable iff (rst)
        (|(clr_all & ~evt_set)) |=> ((req_q & $past(clr_all & ~evt_set)) == '0));

    // R6
    a_r6_mask_store: assert property (@(posedge clk) disable iff (rst)
        mask_wr_en |=> (mask_q == $past(mask_wr_data[SRC_N-1:0])));

    // R7
    a_r7_irq_needs_source: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|(req_q & ~mask_q)));

    // R8
    a_r8_dma_hides_svc: assert property (@(posedge clk) disable iff (rst)
        (dma_mode && ((req_q & ~mask_q & ~fifo_svc_bits()) == '0)) |-> !irq_o);

    // R9
    a_r9_dma_follow: assert property (@(posedge clk) disable iff (rst)
        dma_mode |-> (dma_rx_req_o == req_q[int'(SRC_RX_SVC)] &&
                      dma_tx_req_o == req_q[int'(SRC_TX_SVC)]));

    // R10
    a_r10_dma_quiet: assert property (@(posedge clk) disable iff (rst)
        !dma_mode |-> !(dma_rx_req_o || dma_tx_req_o));
endmodule

bind irq_dma_router irq_dma_router_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .evt_set      (evt_set_i),
    .clr_all      (clr_all),
    .mask_wr_en   (mask_wr_en_i),
    .mask_wr_data (mask_wr_data_i),
    .dma_mode     (dma_mode_i),
    .req_q        (req_q),
    .mask_q       (mask_q),
    .irq_o        (irq_o),
    .dma_rx_req_o (dma_rx_req_o),
    .dma_tx_req_o (dma_tx_req_o)
);

// File: tb/irq_dma_router_tb.sv
module irq_dma_router_tb;
    import irq_route_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [SRC_N-1:0] evt_set_i = '0;
    logic [SRC_N-1:0] clr_strobe_i = '0;
    logic             rx_pop_i = 1'b0;
    logic             tx_push_i = 1'b0;
    logic             mask_wr_en_i = 1'b0;
    logic [BUS_W-1:0] mask_wr_data_i = '0;
    logic             dma_mode_i = 1'b0;
    logic             irq_o, dma_rx_req_o, dma_tx_req_o;
    logic [SRC_N-1:0] req_bits_o, mask_bits_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    bit [SRC_N-1:0] m_req = '0;
    bit [SRC_N-1:0] m_mask = '0;

    always #2.5 clk = ~clk;

    irq_dma_router u_dut (
        .clk(clk), .rst(rst), .evt_set_i(evt_set_i), .clr_strobe_i(clr_strobe_i),
        .rx_pop_i(rx_pop_i), .tx_push_i(tx_push_i), .mask_wr_en_i(mask_wr_en_i),
        .mask_wr_data_i(mask_wr_data_i), .dma_mode_i(dma_mode_i), .irq_o(irq_o),
        .dma_rx_req_o(dma_rx_req_o), .dma_tx_req_o(dma_tx_req_o),
        .req_bits_o(req_bits_o), .mask_bits_o(mask_bits_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        bit e_irq;
        e_irq = 1'b0;
        for (int i = 0; i < SRC_N; i++) begin
            if (m_req[i] && !m_mask[i] && !(dma_mode_i && (i == 5 || i == 6))) e_irq = 1'b1;
        end
        chk(tag, "req", int'(req_bits_o), int'(m_req));
        chk(tag, "mask", int'(mask_bits_o), int'(m_mask));
        chk(tag, "irq", int'(irq_o), int'(e_irq));
        chk(tag, "dma_rx", int'(dma_rx_req_o), dma_mode_i ? int'(m_req[5]) : 0);
        chk(tag, "dma_tx", int'(dma_tx_req_o), dma_mode_i ? int'(m_req[6]) : 0);
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge.
    task automatic step(input bit [SRC_N-1:0] s, input bit [SRC_N-1:0] c, input bit rxp,
                        input bit txp, input bit wen, input bit [31:0] wd, input bit dma,
                        input string tag);
        bit [SRC_N-1:0] nxt;
        evt_set_i = s; clr_strobe_i = c; rx_pop_i = rxp; tx_push_i = txp;
        mask_wr_en_i = wen; mask_wr_data_i = wd; dma_mode_i = dma;
        nxt = m_req;
        for (int i = 0; i < SRC_N; i++) begin
            if (c[i] || (rxp && i == 5) || (txp && i == 6)) nxt[i] = 1'b0;
            if (s[i]) nxt[i] = 1'b1;
        end
        @(posedge clk);
        m_req = nxt;
        if (wen) m_mask = wd[SRC_N-1:0];
        @(negedge clk);
        evt_set_i = '0; clr_strobe_i = '0; rx_pop_i = 1'b0; tx_push_i = 1'b0; mask_wr_en_i = 1'b0;
        compare_all(tag);
    endtask

    task automatic idle(input bit dma, input string tag);
        step('0, '0, 1'b0, 1'b0, 1'b0, 32'h0, dma, tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with stimulus held active during reset
        evt_set_i = '1; mask_wr_en_i = 1'b1; mask_wr_data_i = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; evt_set_i = '0; mask_wr_en_i = 1'b0; mask_wr_data_i = '0;
        m_req = '0; m_mask = '0;
        compare_all("R1");

        // R2/R7: set end-of-command and data-done, unmasked -> irq
        step(13'h0005, '0, 0, 0, 0, 0, 0, "R2");
        idle(0, "R2");
        idle(0, "R7");
        // R3: clear bit 0, then bit 2
        step('0, 13'h0001, 0, 0, 0, 0, 0, "R3");
        step('0, 13'h0004, 0, 0, 0, 0, 0, "R3");
        // R4: set and clear bit 9 in the same cycle
        step(13'h0200, 13'h0200, 0, 0, 0, 0, 0, "R4");
        step('0, 13'h0200, 0, 0, 0, 0, 0, "R3");
        // R5: rx side effect clears bit 5 only
        step(13'h0060, '0, 0, 0, 0, 0, 0, "R5");
        step('0, '0, 1, 0, 0, 0, 0, "R5");
        // R4/R5: tx push concurrent with tx service event keeps bit 6
        step(13'h0040, '0, 0, 1, 0, 0, 0, "R4");
        step('0, '0, 0, 1, 0, 0, 0, "R5");
        // R6: upper write bits dropped
        step('0, '0, 0, 0, 1, 32'hABCD_E123, 0, "R6");
        // R7: masked source gives no irq; unmask lifts it next cycle
        step('0, '0, 0, 0, 1, 32'h0000_1FFF, 0, "R7");
        step(13'h0100, '0, 0, 0, 0, 0, 0, "R7");
        step('0, '0, 0, 0, 1, 32'hFFFF_EEFF, 0, "R7");
        step('0, 13'h0100, 0, 0, 1, 32'h0, 0, "R7");
        // R8/R9: DMA mode with both service bits pending, mask 0
        step(13'h0060, '0, 0, 0, 0, 0, 1, "R8");
        idle(1, "R9");
        step('0, '0, 1, 0, 0, 0, 1, "R9");
        step('0, '0, 0, 1, 0, 0, 1, "R9");
        // R8: another source still raises irq in DMA mode
        step(13'h0060, '0, 0, 0, 0, 0, 1, "R9");
        step(13'h0008, '0, 0, 0, 0, 0, 1, "R8");
        step('0, 13'h0008, 0, 0, 0, 0, 1, "R8");
        // R9: mask register does not gate DMA lines
        step('0, '0, 0, 0, 1, 32'h0000_0060, 1, "R9");
        // R10: DMA off -> lines low, masked service bits stay off irq
        idle(0, "R10");
        step('0, '0, 0, 0, 1, 32'h0, 0, "R10");
        // R1: mid-run reset
        step(13'h1FFF, '0, 0, 0, 1, 32'h0000_0F0F, 0, "R2");
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_req = '0; m_mask = '0;
        compare_all("R1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule